// File: doc/BRIEF.md
# Tagged Receive Character Buffer

This block sits behind the bit-level receiver of a fixed 8N1 serial port. For every character the receiver presents a byte together with a framing-error flag and a break flag, all qualified by a one-cycle strobe. The block queues these characters in a 64-entry first-in first-out store. It shows the oldest character to the processor as one 11-bit read word, which carries the data byte and three status tags. It also reports how many characters are waiting.

Software drains the buffer by popping. Each word is visible before its pop and is consumed by the pop. An empty buffer answers with a word whose empty tag is set, so a driver can keep reading until that tag appears. Two service requests help the processor decide when to drain. A trigger request is raised once the fill reaches a level chosen by a 3-bit code. A timeout request is raised when characters have been waiting and nothing has happened for a chosen number of character times. The character time is given by an external tick. A character arriving at a full buffer is lost and sets a sticky overrun flag, which stays set until it is cleared explicitly.

Top module: `rx_tag_buffer`

## Requirements
- R1: `rd_word` always shows the oldest stored character without consuming it: data byte in bits [7:0], bit 8 = 0, framing-error tag in bit 9, break tag in bit 10. A pop moves the next character into view on the following cycle.
- R2: With the buffer empty, `rd_word` is 11'h100, meaning bit 8 (empty) is set and all other bits are zero. A pop in that state leaves `level` at zero and does not set `ovr_flag`.
- R3: `level` bits [7:0] give the number of stored characters. An accepted write adds one and a pop of a non-empty buffer removes one. If both happen in the same cycle, the count is unchanged.
- R4: The buffer holds 64 characters and returns them in arrival order.
- R5: `trig_req` is high while the fill is at or above the threshold selected by `cfg_trig`: code 0 = 1, 1 = 4, 2 = 8, 3 = 16, 4 = 32, 5 = 48 entries.
- R6: `cfg_trig` codes 6 and 7 select a threshold of 48.
- R7: `cfg_idle` code 0 disables the timeout. Codes 1, 2 and 3 raise `idle_req` once 4, 8 or 16 `char_tick` pulses have been seen while data is waiting, with no write strobe and no pop in between. `idle_req` is never high while the buffer is empty.
- R8: Any write strobe (accepted or not) or any pop restarts the idle count from zero, and `idle_req` is low in the following cycle.
- R9: A write strobe at a full buffer without a pop in the same cycle discards the character, leaves the contents unchanged, and sets `ovr_flag`. The flag stays high until `ovr_clr` is applied with no new overrun in the same cycle.
- R10: A write strobe together with a pop at a full buffer is accepted: the buffer stays full and the new character goes to the tail.
- R11: After a synchronous reset the buffer is empty, `level` is 0, and `trig_req`, `idle_req` and `ovr_flag` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Character strobe from the line receiver |
| in_data | input | 8 | Received byte |
| in_ferr | input | 1 | Framing error seen on this character |
| in_brk | input | 1 | Character was a break condition |
| rd_pop | input | 1 | Processor consumes the shown word |
| char_tick | input | 1 | One pulse per character time |
| cfg_trig | input | 3 | Trigger threshold code |
| cfg_idle | input | 2 | Inactivity timeout code |
| ovr_clr | input | 1 | Clears the overrun flag |
| rd_word | output | 11 | Tagged head word {brk, ferr, empty, data} |
| level | output | 8 | Current fill count |
| trig_req | output | 1 | Fill at or above threshold |
| idle_req | output | 1 | Inactivity timeout with data waiting |
| ovr_flag | output | 1 | Sticky overrun indication |

## Verification
The in-line assertions check the following on every cycle: the fill bound, that a pop on an empty buffer does not change the count, that a full buffer stays full across a simultaneous write and pop, that a rejected write sets the overrun flag, that a timeout is never raised while the buffer is empty, and that a restart clears the timeout. Other behaviour can only be shown by the bench's reference queue, compared on every clock: arrival order and tag placement across all 64 entries, every trigger code at every relevant fill, and the exact tick on which each timeout setting fires. Those scenarios also cover overrun loss with the contents kept intact, and a long random mix of writes, pops, ticks and configuration changes.

// File: rtl/rxb_pkg.sv
package rxb_pkg;

    localparam int BYTE_W  = 8;
    localparam int LEVEL_W = 8;
    localparam int IDLE_W  = 5;

    typedef struct packed {
        logic              brk;
        logic              ferr;
        logic [BYTE_W-1:0] data;
    } rx_entry_t;

    typedef struct packed {
        logic              brk;
        logic              ferr;
        logic              empty;
        logic [BYTE_W-1:0] data;
    } rd_word_t;

    typedef enum logic [1:0] {
        IDLE_OFF = 2'd0,
        IDLE_4   = 2'd1,
        IDLE_8   = 2'd2,
        IDLE_16  = 2'd3
    } idle_sel_e;

    // Fill threshold for a trigger code; codes above 5 alias the top level.
    function automatic logic [LEVEL_W-1:0] trig_threshold(input logic [2:0] code);
        logic [LEVEL_W-1:0] thr;
        case (code)
            3'd0:    thr = LEVEL_W'(1);
            3'd1:    thr = LEVEL_W'(4);
            3'd2:    thr = LEVEL_W'(8);
            3'd3:    thr = LEVEL_W'(16);
            3'd4:    thr = LEVEL_W'(32);
            default: thr = LEVEL_W'(48);
        endcase
        return thr;
    endfunction

    // Number of character times before a timeout; zero means disabled.
    function automatic logic [IDLE_W-1:0] idle_limit(input idle_sel_e sel);
        logic [IDLE_W-1:0] lim;
        case (sel)
            IDLE_4:  lim = IDLE_W'(4);
            IDLE_8:  lim = IDLE_W'(8);
            IDLE_16: lim = IDLE_W'(16);
            default: lim = '0;
        endcase
        return lim;
    endfunction

endpackage

// File: rtl/rxb_store.sv
module rxb_store
    import rxb_pkg::*;
#(
    parameter  int DEPTH = 64,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  logic             pop,
    input  rx_entry_t        din,
    output rx_entry_t        head,
    output logic [CNT_W-1:0] count,
    output logic             empty,
    output logic             full,
    output logic             push_ok,
    output logic             pop_ok
);

    rx_entry_t        mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr;
    logic [PTR_W-1:0] rd_ptr;

    function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign empty   = (count == '0);
    assign full    = (count == CNT_W'(DEPTH));
    assign pop_ok  = pop && !empty;
    assign push_ok = push && (!full || pop_ok);
    assign head    = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (push_ok) begin
            mem[wr_ptr] <= din;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push_ok) begin
                wr_ptr <= ptr_inc(wr_ptr);
            end
            if (pop_ok) begin
                rd_ptr <= ptr_inc(rd_ptr);
            end
            case ({push_ok, pop_ok})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    AST_FILL_BOUND: assert property (@(posedge clk) disable iff (rst)
        count <= CNT_W'(DEPTH)); // R4

    AST_EMPTY_POP_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (pop && empty && !push) |=> (count == '0)); // R2

    AST_FULL_SWAP_STAYS_FULL: assert property (@(posedge clk) disable iff (rst)
        (full && push && pop) |=> full); // R10

endmodule

// File: rtl/rxb_idle.sv
module rxb_idle
    import rxb_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      char_tick,
    input  logic      restart,
    input  logic      has_data,
    input  idle_sel_e sel,
    output logic      idle_req
);

    localparam logic [IDLE_W-1:0] SAT = IDLE_W'(16);

    logic [IDLE_W-1:0] ticks;
    logic [IDLE_W-1:0] lim;

    assign lim = idle_limit(sel);

    always_ff @(posedge clk) begin
        if (rst) begin
            ticks <= '0;
        end else if (restart || !has_data) begin
            ticks <= '0;
        end else if (char_tick && ticks < SAT) begin
            ticks <= ticks + 1'b1;
        end
    end

    assign idle_req = (sel != IDLE_OFF) && has_data && (ticks >= lim);

    AST_IDLE_NEEDS_DATA: assert property (@(posedge clk) disable iff (rst)
        idle_req |-> has_data); // R7

    AST_RESTART_CLEARS: assert property (@(posedge clk) disable iff (rst)
        restart |=> !idle_req); // R8

endmodule

// File: rtl/rxb_flags.sv
module rxb_flags
    import rxb_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [LEVEL_W-1:0] fill,
    input  logic [2:0]         trig_code,
    input  logic               push,
    input  logic               push_ok,
    input  logic               ovr_clr,
    output logic               trig_req,
    output logic               ovr_flag
);

    logic [LEVEL_W-1:0] thr;

    assign thr      = trig_threshold(trig_code);
    assign trig_req = (fill >= thr);

    always_ff @(posedge clk) begin
        if (rst) begin
            ovr_flag <= 1'b0;
        end else if (push && !push_ok) begin
            ovr_flag <= 1'b1;
        end else if (ovr_clr) begin
            ovr_flag <= 1'b0;
        end
    end

    AST_LOST_WRITE_FLAGS: assert property (@(posedge clk) disable iff (rst)
        (push && !push_ok) |=> ovr_flag); // R9

    AST_HIGH_CODES_AT_48: assert property (@(posedge clk) disable iff (rst)
        (trig_code >= 3'd5 && fill >= LEVEL_W'(48)) |-> trig_req); // R6

endmodule

// File: rtl/rx_tag_buffer.sv
module rx_tag_buffer
    import rxb_pkg::*;
#(
    parameter  int DEPTH = 64,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        in_valid,
    input  logic [7:0]  in_data,
    input  logic        in_ferr,
    input  logic        in_brk,
    input  logic        rd_pop,
    input  logic        char_tick,
    input  logic [2:0]  cfg_trig,
    input  logic [1:0]  cfg_idle,
    input  logic        ovr_clr,
    output logic [10:0] rd_word,
    output logic [7:0]  level,
    output logic        trig_req,
    output logic        idle_req,
    output logic        ovr_flag
);

    rx_entry_t          din;
    rx_entry_t          head;
    rd_word_t           word;
    logic [CNT_W-1:0]   count;
    logic               empty;
    logic               full;
    logic               push_ok;
    logic               pop_ok;
    logic [LEVEL_W-1:0] fill;

    assign din = '{brk: in_brk, ferr: in_ferr, data: in_data};

    rxb_store #(.DEPTH(DEPTH)) u_store (
        .clk     (clk),
        .rst     (rst),
        .push    (in_valid),
        .pop     (rd_pop),
        .din     (din),
        .head    (head),
        .count   (count),
        .empty   (empty),
        .full    (full),
        .push_ok (push_ok),
        .pop_ok  (pop_ok)
    );

    assign fill = LEVEL_W'(count);

    rxb_idle u_idle (
        .clk       (clk),
        .rst       (rst),
        .char_tick (char_tick),
        .restart   (in_valid || rd_pop),
        .has_data  (!empty),
        .sel       (idle_sel_e'(cfg_idle)),
        .idle_req  (idle_req)
    );

    rxb_flags u_flags (
        .clk       (clk),
        .rst       (rst),
        .fill      (fill),
        .trig_code (cfg_trig),
        .push      (in_valid),
        .push_ok   (push_ok),
        .ovr_clr   (ovr_clr),
        .trig_req  (trig_req),
        .ovr_flag  (ovr_flag)
    );

    always_comb begin
        if (empty) begin
            word       = '0;
            word.empty = 1'b1;
        end else begin
            word.brk   = head.brk;
            word.ferr  = head.ferr;
            word.empty = 1'b0;
            word.data  = head.data;
        end
    end

    assign rd_word = word;
    assign level   = fill;

    AST_EMPTY_TAG_ONLY_WHEN_ZERO: assert property (@(posedge clk) disable iff (rst)
        rd_word[8] |-> (level == 8'd0)); // R2

    AST_POP_DRAINS_ONE: assert property (@(posedge clk) disable iff (rst)
        (rd_pop && !in_valid && level != 8'd0) |=> (level == $past(level) - 8'd1)); // R3

    AST_TRIG_OFF_WHEN_EMPTY: assert property (@(posedge clk) disable iff (rst)
        (level == 8'd0) |-> !trig_req); // R5

endmodule

// File: tb/rx_tag_buffer_bench.sv
module rx_tag_buffer_bench;

    localparam int DEPTH = 64;

    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid, in_ferr, in_brk, rd_pop, char_tick, ovr_clr;
    logic [7:0]  in_data;
    logic [2:0]  cfg_trig;
    logic [1:0]  cfg_idle;
    logic [10:0] rd_word;
    logic [7:0]  level;
    logic        trig_req, idle_req, ovr_flag;

    always #4 clk = ~clk;

    rx_tag_buffer #(.DEPTH(DEPTH)) u_rx_tag_buffer (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
        .in_ferr(in_ferr), .in_brk(in_brk), .rd_pop(rd_pop),
        .char_tick(char_tick), .cfg_trig(cfg_trig), .cfg_idle(cfg_idle),
        .ovr_clr(ovr_clr), .rd_word(rd_word), .level(level),
        .trig_req(trig_req), .idle_req(idle_req), .ovr_flag(ovr_flag)
    );

    // Reference model state
    logic [9:0] mq[$];      // {brk, ferr, data}
    int         m_idle;
    bit         m_ovr;
    int         vectors = 0;
    int         errors  = 0;
    bit         done    = 0;

    function automatic int ref_thr(input logic [2:0] c);
        case (c)
            3'd0: return 1;
            3'd1: return 4;
            3'd2: return 8;
            3'd3: return 16;
            3'd4: return 32;
            default: return 48;
        endcase
    endfunction

    function automatic int ref_lim(input logic [1:0] c);
        case (c)
            2'd1: return 4;
            2'd2: return 8;
            2'd3: return 16;
            default: return 0;
        endcase
    endfunction

    task automatic compare(input string tag);
        logic [10:0] e_word;
        logic [7:0]  e_lvl;
        logic        e_trig, e_idle;
        bit          bad = 0;
        e_word = (mq.size() == 0) ? 11'h100 : {mq[0][9], mq[0][8], 1'b0, mq[0][7:0]};
        e_lvl  = 8'(mq.size());
        e_trig = (mq.size() >= ref_thr(cfg_trig));
        e_idle = (cfg_idle != 2'd0) && (mq.size() != 0) && (m_idle >= ref_lim(cfg_idle));
        vectors++;
        if (rd_word !== e_word) begin
            $display("FAIL R1 [%s] rd_word=%h expected=%h", tag, rd_word, e_word); bad = 1;
        end
        if (level !== e_lvl) begin
            $display("FAIL R3 [%s] level=%0d expected=%0d", tag, level, e_lvl); bad = 1;
        end
        if (trig_req !== e_trig) begin
            $display("FAIL R5 [%s] trig_req=%b expected=%b", tag, trig_req, e_trig); bad = 1;
        end
        if (idle_req !== e_idle) begin
            $display("FAIL R7 [%s] idle_req=%b expected=%b", tag, idle_req, e_idle); bad = 1;
        end
        if (ovr_flag !== m_ovr) begin
            $display("FAIL R9 [%s] ovr_flag=%b expected=%b", tag, ovr_flag, m_ovr); bad = 1;
        end
        if (bad) errors++;
    endtask

    // One clock: drive inputs, update the model at the edge, compare at the falling edge.
    task automatic cyc(input bit v, input logic [7:0] d, input bit fe, input bit bk,
                       input bit p, input bit t, input bit c, input string tag);
        int  sz;
        bit  pop_ok, push_ok;
        in_valid = v; in_data = d; in_ferr = fe; in_brk = bk;
        rd_pop = p; char_tick = t; ovr_clr = c;
        @(posedge clk);
        sz      = mq.size();
        pop_ok  = p && sz != 0;
        push_ok = v && (sz != DEPTH || pop_ok);
        if (v || p || sz == 0) m_idle = 0;
        else if (t && m_idle < 16) m_idle++;
        if (v && !push_ok) m_ovr = 1;
        else if (c) m_ovr = 0;
        if (pop_ok) void'(mq.pop_front());
        if (push_ok) mq.push_back({bk, fe, d});
        @(negedge clk);
        in_valid = 0; rd_pop = 0; char_tick = 0; ovr_clr = 0;
        compare(tag);
    endtask

    task automatic idle_cyc(input string tag);
        cyc(0, 8'h00, 0, 0, 0, 0, 0, tag);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    initial begin
        rst = 1; in_valid = 0; in_data = 0; in_ferr = 0; in_brk = 0;
        rd_pop = 0; char_tick = 0; ovr_clr = 0; cfg_trig = 3'd0; cfg_idle = 2'd0;
        m_idle = 0; m_ovr = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        compare("R11 reset state");

        // R2: pop of an empty buffer
        cyc(0, 8'h00, 0, 0, 1, 0, 0, "R2 pop empty");
        cyc(0, 8'h00, 0, 0, 1, 1, 0, "R2 pop empty again");

        // R1 tags and show-ahead, R3 counting
        cyc(1, 8'hA5, 0, 0, 0, 0, 0, "R1 plain byte");
        cyc(1, 8'h3C, 1, 0, 0, 0, 0, "R1 ferr tag");
        cyc(1, 8'h00, 1, 1, 0, 0, 0, "R1 break tag");
        idle_cyc("R1 head held");
        cyc(1, 8'h77, 0, 0, 1, 0, 0, "R3 push and pop together");
        cyc(0, 8'h00, 0, 0, 1, 0, 0, "R1 next head");
        cyc(0, 8'h00, 0, 0, 1, 0, 0, "R3 pop");
        cyc(0, 8'h00, 0, 0, 1, 0, 0, "R3 pop to empty");

        // R5 / R6: sweep every trigger code at every fill up to 50
        for (int n = 1; n <= 50; n++) begin
            cyc(1, 8'(n), 0, 0, 0, 0, 0, "R5 fill");
            for (int c = 0; c < 8; c++) begin
                cfg_trig = 3'(c);
                idle_cyc((c >= 6) ? "R6 alias code" : "R5 code");
            end
        end
        while (mq.size() != 0) cyc(0, 8'h00, 0, 0, 1, 0, 0, "R4 drain");
        cfg_trig = 3'd2;

        // R4 full, R9 overrun, R10 push with pop at full
        for (int n = 0; n < DEPTH; n++) cyc(1, 8'(n + 100), n[0], n[1], 0, 0, 0, "R4 fill to 64");
        cyc(1, 8'hEE, 0, 0, 0, 0, 0, "R9 write at full lost");
        idle_cyc("R9 flag sticky");
        cyc(1, 8'hD1, 1, 0, 1, 0, 0, "R10 write with pop at full");
        cyc(1, 8'hEF, 0, 0, 0, 0, 1, "R9 new overrun beats clear");
        cyc(0, 8'h00, 0, 0, 0, 0, 1, "R9 clear");
        while (mq.size() != 0) cyc(0, 8'h00, 0, 0, 1, 0, 0, "R4 ordered drain");

        // R7 / R8: each timeout setting
        for (int m = 0; m < 4; m++) begin
            cfg_idle = 2'(m);
            cyc(1, 8'h55, 0, 0, 0, 0, 0, "R7 arm");
            for (int k = 0; k < 20; k++) cyc(0, 8'h00, 0, 0, 0, 1, 0, "R7 tick");
            cyc(1, 8'h56, 0, 0, 0, 0, 0, "R8 arrival restarts");
            for (int k = 0; k < 6; k++) cyc(0, 8'h00, 0, 0, 0, 1, 0, "R8 tick after arrival");
            cyc(0, 8'h00, 0, 0, 1, 0, 0, "R8 pop restarts");
            for (int k = 0; k < 18; k++) cyc(0, 8'h00, 0, 0, 0, k[0], 0, "R7 slow ticks");
            while (mq.size() != 0) cyc(0, 8'h00, 0, 0, 1, 1, 0, "R7 drain");
            for (int k = 0; k < 20; k++) cyc(0, 8'h00, 0, 0, 0, 1, 0, "R7 empty no timeout");
        end

        // Random mix
        for (int i = 0; i < 4000; i++) begin
            if ($urandom % 50 == 0) cfg_trig = 3'($urandom);
            if ($urandom % 50 == 0) cfg_idle = 2'($urandom);
            cyc(($urandom % 5) < 3, 8'($urandom), ($urandom % 7) == 0, ($urandom % 11) == 0,
                ($urandom % 5) < ((i / 500) % 2 == 0 ? 1 : 3), ($urandom % 3) == 0,
                ($urandom % 40) == 0, "random mix");
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

endmodule